// File: doc/BRIEF.md
# Control Register Bank Behind a Two-Wire Serial Target

This block is an I2C target that keeps sixteen 8-bit control locations and presents their decoded fields as parallel outputs. Those outputs set three channel gains, a shared contrast, four 8-bit converter codes, a black-level offset, an overlay level, blanking and power-save flags, converter range controls, an amplifier bandwidth code and a clamp polarity. A fast system clock samples SCL and SDA through two-stage synchronizers, and the target drives SDA only through an open-drain enable.

A host writes with a transfer made of the device address, a pointer byte and one or more data bytes. To read, the host first sends a write that carries only the pointer and ends with a stop. It then opens a second transfer with the read address, and the target returns bytes starting at the stored pointer. A bit in the control location 0x0A can hold the pointer fixed during writes. A self-clearing bit in 0x0F restores every other location to its power-on value and leaves the transfer in progress undisturbed.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: The target acknowledges only the address bytes 0xDC (write) and 0xDD (read), which is the 7-bit address 0x6E with the read flag in bit 0. It acknowledges by holding SDA low through the ninth SCL high phase. It leaves SDA released for any other address byte and ignores the rest of that transfer.
- R2: In a write, the byte after the address loads the pointer. Each later data byte is acknowledged and stored at the pointer.
- R3: When bit 0 of 0x0A is 0, the pointer advances by one after each data byte written.
- R4: When bit 0 of 0x0A is 1, the pointer stays fixed during writes, so successive data bytes rewrite the same location. The value of this bit before a byte is written decides whether the pointer moves after that byte.
- R5: A read transfer returns bytes MSB first, starting at the pointer set by the preceding write. The pointer advances after every byte returned, whatever the value of 0x0A bit 0. A master NACK ends the read and releases SDA.
- R6: After reset, the locations hold these values: 0x00–0x03 = 0x60, 0x04–0x07 = 0x80, 0x08 = 0x15, 0x0B = 0x04, and 0x00 everywhere else.
- R7: Bits that are not assigned to a field read back as 0 whatever value is written. The writable masks are: 0x00–0x03 0x7F, 0x04–0x07 0xFF, 0x08 0x1F, 0x09 0x1B, 0x0A 0x01, 0x0B 0x0F, 0x0F 0x01.
- R8: Locations 0x0C–0x0E and 0x10–0xFF keep no data. Writes to them are acknowledged and discarded, and reads from them return 0x00.
- R9: Writing a 1 to bit 0 of 0x0F restores the R6 values in all other locations on the next clock. The bit then reads 0. The current transfer continues, and its later data bytes are still acknowledged and stored.
- R10: A stop condition at any point returns the target to idle with SDA released.
- R11: The outputs carry these fields:
  - gains: gain_r, gain_g and gain_b come from bits 6:0 of 0x00, 0x01 and 0x02.
  - contrast: contrast comes from bits 6:0 of 0x03.
  - converter codes: dac1_code through dac4_code come from 0x04 through 0x07.
  - 0x08: bits 2:0 drive dc_offset and bits 4:3 drive osd_level.
  - 0x09: bit 0 drives blank_video, bit 1 power_save, bit 3 dac_half_range and bit 4 dac_bright_mix.
  - 0x0A: bit 0 drives incr_hold.
  - 0x0B: bits 2:0 drive bw_sel and bit 3 drives clamp_neg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| gain_r | output | 7 | Red channel gain |
| gain_g | output | 7 | Green channel gain |
| gain_b | output | 7 | Blue channel gain |
| contrast | output | 7 | Shared contrast |
| dac1_code | output | 8 | Converter 1 code |
| dac2_code | output | 8 | Converter 2 code |
| dac3_code | output | 8 | Converter 3 code |
| dac4_code | output | 8 | Converter 4 code |
| dc_offset | output | 3 | Black-level offset step |
| osd_level | output | 2 | Overlay contrast level |
| blank_video | output | 1 | Force video blank |
| power_save | output | 1 | Output stage off |
| dac_half_range | output | 1 | Halve range of converters 1–3 |
| dac_bright_mix | output | 1 | Add half of converter 4 to converters 1–3 |
| incr_hold | output | 1 | Pointer held fixed during writes |
| bw_sel | output | 3 | Amplifier bandwidth code |
| clamp_neg | output | 1 | Clamp pulse is negative-going |

## Verification
The assertions assume a well-formed bus. The master changes SDA only while SCL is low, except when it makes a start or a stop. It never makes a start or stop while the target holds SDA low. Each SCL phase also lasts several system clocks, which covers the synchronizer delay. The bench's master tasks hold every SCL phase for ten clocks and change SDA only in the low phase. It releases SDA during acknowledge slots and data the target returns, and issues stops only after a NACK or while the target has SDA released. The random part chooses pointers, lengths and data, and that includes pointers to unmapped addresses, writes to the hold bit and soft-reset writes.

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int         NREG     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [6:0] gain_r,
  output logic [6:0] gain_g,
  output logic [6:0] gain_b,
  output logic [6:0] contrast,
  output logic [7:0] dac1_code,
  output logic [7:0] dac2_code,
  output logic [7:0] dac3_code,
  output logic [7:0] dac4_code,
  output logic [2:0] dc_offset,
  output logic [1:0] osd_level,
  output logic       blank_video,
  output logic       power_save,
  output logic       dac_half_range,
  output logic       dac_bright_mix,
  output logic       incr_hold,
  output logic [2:0] bw_sel,
  output logic       clamp_neg
);
  localparam int AW = $clog2(NREG);
  localparam int SRST = NREG - 1;
  localparam int HOLD = 10;

  typedef enum logic [3:0] {S_IDLE, S_DEV, S_DEVACK, S_PTR, S_PTRACK,
                            S_WR, S_WRACK, S_RD, S_RDACK} st_t;

  function automatic logic [7:0] wmask(input logic [AW-1:0] a);
    case (a)
      4'h0, 4'h1, 4'h2, 4'h3: wmask = 8'h7F;
      4'h4, 4'h5, 4'h6, 4'h7: wmask = 8'hFF;
      4'h8: wmask = 8'h1F;
      4'h9: wmask = 8'h1B;
      4'hA: wmask = 8'h01;
      4'hB: wmask = 8'h0F;
      4'hF: wmask = 8'h01;
      default: wmask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] dflt(input logic [AW-1:0] a);
    case (a)
      4'h0, 4'h1, 4'h2, 4'h3: dflt = 8'h60;
      4'h4, 4'h5, 4'h6, 4'h7: dflt = 8'h80;
      4'h8: dflt = 8'h15;
      4'hB: dflt = 8'h04;
      default: dflt = 8'h00;
    endcase
  endfunction

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start, stop;
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, rdval;
  logic       rw, mnack;
  logic [7:0] rf [NREG];
  logic       in_map;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  assign scl_s    = scl_p[1];
  assign scl_q    = scl_p[2];
  assign sda_s    = sda_p[1];
  assign sda_q    = sda_p[2];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign in_map   = (ptr[7:AW] == '0);
  assign rdval    = in_map ? rf[ptr[AW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mnack  <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= dflt(AW'(i));
    end else begin
      if (rf[SRST][0]) begin
        for (int i = 0; i < NREG; i++)
          if (i != SRST) rf[i] <= dflt(AW'(i));
        rf[SRST] <= 8'h00;
      end
      if (stop) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start) begin
        state  <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_PTR, S_WR:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_DEV) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= S_DEVACK;
                end else state <= S_IDLE;
              end else if (state == S_PTR) begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                state  <= S_PTRACK;
              end else begin
                if (in_map) rf[ptr[AW-1:0]] <= sh & wmask(ptr[AW-1:0]);
                if (!rf[HOLD][0]) ptr <= ptr + 8'd1;
                sda_oe <= 1'b1;
                state  <= S_WRACK;
              end
            end
          S_DEVACK, S_PTRACK, S_WRACK:
            if (scl_fall) begin
              cnt <= '0;
              if (state == S_DEVACK && rw) begin
                sh     <= rdval;
                sda_oe <= ~rdval[7];
                ptr    <= ptr + 8'd1;
                state  <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == S_DEVACK) ? S_PTR : S_WR;
              end
            end
          S_RD:
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_RDACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          S_RDACK:
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (mnack) state <= S_IDLE;
              else begin
                sh     <= rdval;
                sda_oe <= ~rdval[7];
                ptr    <= ptr + 8'd1;
                state  <= S_RD;
              end
            end
          default: ;
        endcase
      end
    end

  assign gain_r         = rf[0][6:0];
  assign gain_g         = rf[1][6:0];
  assign gain_b         = rf[2][6:0];
  assign contrast       = rf[3][6:0];
  assign dac1_code      = rf[4];
  assign dac2_code      = rf[5];
  assign dac3_code      = rf[6];
  assign dac4_code      = rf[7];
  assign dc_offset      = rf[8][2:0];
  assign osd_level      = rf[8][4:3];
  assign blank_video    = rf[9][0];
  assign power_save     = rf[9][1];
  assign dac_half_range = rf[9][3];
  assign dac_bright_mix = rf[9][4];
  assign incr_hold      = rf[HOLD][0];
  assign bw_sel         = rf[11][2:0];
  assign clamp_neg      = rf[11][3];

  p_pull_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
  p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDACK && scl_fall && !mnack && !start && !stop) |=> (ptr == $past(ptr) + 8'd1));
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rf[0][7] && !rf[3][7] && rf[8][7:5] == 3'd0 && rf[9][2] == 1'b0 &&
     rf[9][7:5] == 3'd0 && rf[HOLD][7:1] == 7'd0 && rf[11][7:4] == 4'd0));
  p_srst_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf[SRST][0] |=> (!rf[SRST][0] && rf[0] == 8'h60 && rf[8] == 8'h15 && rf[HOLD] == 8'h00));
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == S_IDLE && !sda_oe));
endmodule

// File: tb/sim_i2c_ctrl_regs.sv
`timescale 1ns/1ps
module sim_i2c_ctrl_regs;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, mscl = 1'b1, msda = 1'b1;
  logic sda_oe, sda_ln;
  logic [6:0] gain_r, gain_g, gain_b, contrast;
  logic [7:0] dac1_code, dac2_code, dac3_code, dac4_code;
  logic [2:0] dc_offset, bw_sel;
  logic [1:0] osd_level;
  logic blank_video, power_save, dac_half_range, dac_bright_mix, incr_hold, clamp_neg;
  int nchk = 0, nerr = 0;
  logic [7:0] m [16];
  logic [7:0] wd [4];

  always #2.5 clk = ~clk;
  assign sda_ln = msda & ~sda_oe;

  i2c_ctrl_regs u0 (.clk(clk), .rst_n(rst_n), .scl_i(mscl), .sda_i(sda_ln), .sda_oe(sda_oe),
    .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b), .contrast(contrast),
    .dac1_code(dac1_code), .dac2_code(dac2_code), .dac3_code(dac3_code), .dac4_code(dac4_code),
    .dc_offset(dc_offset), .osd_level(osd_level), .blank_video(blank_video),
    .power_save(power_save), .dac_half_range(dac_half_range), .dac_bright_mix(dac_bright_mix),
    .incr_hold(incr_hold), .bw_sel(bw_sel), .clamp_neg(clamp_neg));

  function automatic logic [7:0] bmask(input int a);
    if (a < 4) return 8'h7F;
    if (a < 8) return 8'hFF;
    case (a)
      8: return 8'h1F;
      9: return 8'h1B;
      10: return 8'h01;
      11: return 8'h0F;
      15: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bdef(input int a);
    if (a < 4) return 8'h60;
    if (a < 8) return 8'h80;
    if (a == 8) return 8'h15;
    if (a == 11) return 8'h04;
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(posedge clk); #1; endtask
  task automatic i2c_start; msda = 1; qw; mscl = 1; qw; msda = 0; qw; mscl = 0; qw; endtask
  task automatic i2c_stop; msda = 0; qw; mscl = 1; qw; msda = 1; qw; endtask

  task automatic tx(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; qw; mscl = 1; qw; qw; mscl = 0; qw;
    end
    msda = 1; qw; mscl = 1; qw; ack = !sda_ln; qw; mscl = 0; qw;
  endtask

  task automatic rx(input logic nack, output logic [7:0] b);
    msda = 1;
    for (int i = 7; i >= 0; i--) begin
      mscl = 1; qw; b[i] = sda_ln; qw; mscl = 0; qw;
    end
    msda = nack; qw; mscl = 1; qw; qw; mscl = 0; qw; msda = 1; qw;
  endtask

  task automatic mwrite(input int p0, input int n);
    logic a; logic inc; int p;
    i2c_start;
    tx(8'hDC, a); chk(a, "R1 write address ack", a, 1);
    tx(8'(p0), a); chk(a, "R2 pointer ack", a, 1);
    p = p0;
    for (int k = 0; k < n; k++) begin
      tx(wd[k], a); chk(a, "R8 data ack", a, 1);
      inc = !m[10][0];
      if (p < 16) m[p] = wd[k] & bmask(p);
      if (p == 15 && wd[k][0]) begin
        for (int i = 0; i < 15; i++) m[i] = bdef(i);
        m[15] = 8'h00;
      end
      if (inc) p = (p + 1) & 255;
    end
    i2c_stop;
  endtask

  task automatic mread(input int p0, input int n, input string req);
    logic a; logic [7:0] b; int p;
    i2c_start; tx(8'hDC, a); tx(8'(p0), a); i2c_stop;
    i2c_start; tx(8'hDD, a); chk(a, "R1 read address ack", a, 1);
    p = p0;
    for (int k = 0; k < n; k++) begin
      rx(k == n - 1, b);
      chk(b == ((p < 16) ? m[p] : 8'h00), req, b, (p < 16) ? m[p] : 8'h00);
      p = (p + 1) & 255;
    end
    i2c_stop;
    chk(!sda_oe, "R10 released after stop", sda_oe, 0);
  endtask

  task automatic chk_outs;
    chk({gain_r, gain_g, gain_b, contrast} == {m[0][6:0], m[1][6:0], m[2][6:0], m[3][6:0]},
        "R11 gain fields", {gain_r, gain_g, gain_b, contrast}, {m[0][6:0], m[1][6:0], m[2][6:0], m[3][6:0]});
    chk({dac1_code, dac2_code, dac3_code, dac4_code} == {m[4], m[5], m[6], m[7]},
        "R11 converter codes", {dac1_code, dac2_code, dac3_code, dac4_code}, {m[4], m[5], m[6], m[7]});
    chk({dc_offset, osd_level, blank_video, power_save, dac_half_range, dac_bright_mix, incr_hold, bw_sel, clamp_neg} ==
        {m[8][2:0], m[8][4:3], m[9][0], m[9][1], m[9][3], m[9][4], m[10][0], m[11][2:0], m[11][3]},
        "R11 control fields",
        {dc_offset, osd_level, blank_video, power_save, dac_half_range, dac_bright_mix, incr_hold, bw_sel, clamp_neg},
        {m[8][2:0], m[8][4:3], m[9][0], m[9][1], m[9][3], m[9][4], m[10][0], m[11][2:0], m[11][3]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic a; int s;
    s = $urandom(32'd2024);
    for (int i = 0; i < 16; i++) m[i] = bdef(i);
    repeat (5) @(posedge clk); #1; rst_n = 1; qw;
    chk(!sda_oe, "R6 SDA released at reset", sda_oe, 0);
    chk_outs;
    mread(0, 16, "R6 default readback");

    i2c_start; tx(8'hA0, a); chk(!a, "R1 foreign address not acked", a, 0);
    tx(8'h00, a); chk(!a, "R1 foreign transfer ignored", a, 0); i2c_stop;
    mread(0, 1, "R1 register untouched by foreign transfer");

    wd[0] = 8'hFF; wd[1] = 8'hFF; wd[2] = 8'hFF; wd[3] = 8'hFF;
    mwrite(8, 4); mread(8, 4, "R7 reserved bits read zero");
    wd[0] = 8'h5A; wd[1] = 8'hA5; mwrite(12, 2); mread(12, 2, "R8 unmapped reads zero");
    wd[0] = 8'h33; mwrite(8'h20, 1); mread(8'h1F, 2, "R8 high unmapped reads zero");
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; mwrite(0, 3); mread(0, 4, "R3 auto-increment write");
    chk_outs;

    wd[0] = 8'h01; mwrite(10, 1);
    wd[0] = 8'h0A; wd[1] = 8'h0B; wd[2] = 8'h4C; mwrite(4, 3);
    mread(4, 3, "R4 held pointer rewrites one location");
    chk(incr_hold, "R4 hold output", incr_hold, 1);

    wd[0] = 8'h01; wd[1] = 8'h00; mwrite(15, 2);
    mread(0, 16, "R9 soft reset reload");
    chk_outs;

    wd[0] = 8'h44; wd[1] = 8'h01; wd[2] = 8'h12; mwrite(2, 3);
    mread(2, 1, "R9 byte after soft reset stored");

    i2c_start; tx(8'hDC, a); tx(8'h03, a); i2c_stop;
    chk(!sda_oe, "R10 stop mid write", sda_oe, 0);

    for (int it = 0; it < 30; it++) begin
      int p, n;
      p = $urandom_range(0, 19); n = $urandom_range(1, 4);
      for (int k = 0; k < 4; k++) wd[k] = 8'($urandom);
      if (p == 15 && $urandom_range(0, 1) == 0) wd[0][0] = 1'b0;
      mwrite(p, n);
      if (it % 6 == 5) begin
        mread(0, 18, "R2 random write readback");
        chk_outs;
      end
    end
    chk_outs;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule